// File: doc/BRIEF.md
# Passive Serial Configuration Host Controller

This block is the host-side master for loading a slave device through its passive serial configuration port. On a start pulse it holds the target's active-low configuration reset for a set number of system clocks and then releases it. It then waits for the target's active-low status line to read high. After that it pulls configuration bytes from a valid/ready byte stream and shifts each one out on a single data line, least significant bit first. The serial clock it generates is the system clock divided down.

The data phase has no fixed length. It ends when the target raises its loaded flag, even if the stream still holds bytes. The controller then completes the bit that is in flight and adds one further full clock pulse, so the target sees exactly two falling edges after its loaded flag. It then waits for a low-to-high edge on the target's ready line, which marks entry into user mode. The result is reported on sticky done and error outputs. Busy covers the whole attempt. The following conditions end the attempt with an error: any timed wait expires, the stream runs dry, or the target pulls its status low during the data phase.

Top module: `ps_serial_cfg_host`

## Requirements
- R1: After reset, tgt_reset_n is high, ser_clk and ser_dat are low, and busy, done, error and in_ready are all low.
- R2: A start pulse seen in idle drives tgt_reset_n low for exactly PULSE_CLKS system clocks and clears done and error. Busy rises in the first low cycle. A start pulse seen while busy has no effect.
- R3: After tgt_reset_n rises, no ser_clk pulse is produced and no byte is taken until tgt_ok is high. If tgt_ok stays low for WAIT_CLKS clocks, error is set and the controller returns to idle.
- R4: Each accepted byte goes out least significant bit first, one bit per ser_clk pulse. Each ser_clk half period lasts DIV_HALF system clocks. For example, 0x1B is sent as 1,1,0,1,1,0,0,0.
- R5: ser_dat changes only on the clock edge where ser_clk falls or while ser_clk is low. It is stable across every rising edge of ser_clk.
- R6: A byte is taken on a clock where in_valid and in_ready are both high. in_ready is high only between bytes in the data phase, while tgt_ok is high and tgt_loaded is low.
- R7: When tgt_loaded is high at a bit boundary, the data phase ends at once. No further byte is accepted and no further stream bit is sent.
- R8: Counting the fall that ends the bit in flight, exactly two ser_clk falling edges follow tgt_loaded going high, and ser_dat is low after the first of them. If tgt_loaded is seen between bytes, two full extra pulses are sent.
- R9: After the trailing pulses, done is set on the first low-to-high change of tgt_ready. If tgt_ready is already high with no rising edge, or no edge comes within WAIT_CLKS clocks, error is set instead.
- R10: If no byte is offered for WAIT_CLKS clocks while the data phase waits for one, error is set.
- R11: If tgt_ok is low during the data phase, the attempt aborts on the next clock. ser_clk and ser_dat go low, error is set and busy falls.
- R12: Busy falls on exactly the clock where done or error is set. Done and error are never high together, and both hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a configuration attempt (honoured only when idle) |
| in_data | input | 8 | Configuration byte from the stream |
| in_valid | input | 1 | Stream byte available |
| in_ready | output | 1 | Byte accepted this clock when in_valid is also high |
| tgt_reset_n | output | 1 | Active-low configuration reset to the target |
| tgt_ok | input | 1 | Target status, high when the target is ready and has seen no error |
| tgt_loaded | input | 1 | Target flag: configuration data fully received |
| tgt_ready | input | 1 | Target flag: initialization complete |
| ser_clk | output | 1 | Generated serial configuration clock |
| ser_dat | output | 1 | Serial configuration data |
| busy | output | 1 | Attempt in progress |
| done | output | 1 | Last attempt reached user mode |
| error | output | 1 | Last attempt failed |

## Verification
The state machine and its counters are visible almost cycle by cycle on the ports. A wrong phase count or a slipped byte-boundary state shows as a ser_clk edge one or more system clocks off, or as in_ready high in a cycle where it should be low. Both show within one serial bit, and the bench compares every output against its reference model on every clock. Errors in bit order or in trailing-pulse counting are also caught by the emulated target. It records every sampled bit and every falling edge after its loaded flag. The result is compared against the expected least-significant-first stream once the attempt ends.

// File: rtl/ps_serial_cfg_host.sv
module ps_serial_cfg_host #(
  parameter int DIV_HALF   = 2,
  parameter int PULSE_CLKS = 8,
  parameter int WAIT_CLKS  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       tgt_reset_n,
  input  logic       tgt_ok,
  input  logic       tgt_loaded,
  input  logic       tgt_ready,
  output logic       ser_clk,
  output logic       ser_dat,
  output logic       busy,
  output logic       done,
  output logic       error
);

  localparam int M1   = (PULSE_CLKS > WAIT_CLKS) ? PULSE_CLKS : WAIT_CLKS;
  localparam int MAXC = (M1 > DIV_HALF) ? M1 : DIV_HALF;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] P_END = CW'(PULSE_CLKS - 1);
  localparam logic [CW-1:0] W_END = CW'(WAIT_CLKS - 1);
  localparam logic [CW-1:0] H_END = CW'(DIV_HALF - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PULSE, S_WOK, S_LOAD, S_SHIFT, S_TAIL, S_WINIT
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          tails;
  logic          init_q;

  assign in_ready = (st == S_LOAD) && tgt_ok && !tgt_loaded;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      sh          <= '0;
      bitn        <= '0;
      tails       <= 1'b0;
      init_q      <= 1'b0;
      tgt_reset_n <= 1'b1;
      ser_clk     <= 1'b0;
      ser_dat     <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
    end else begin
      init_q <= tgt_ready;
      case (st)
        S_IDLE: if (start) begin
          st          <= S_PULSE;
          cnt         <= '0;
          tgt_reset_n <= 1'b0;
          done        <= 1'b0;
          error       <= 1'b0;
        end
        S_PULSE: if (cnt == P_END) begin
          tgt_reset_n <= 1'b1;
          st          <= S_WOK;
          cnt         <= '0;
        end else cnt <= cnt + CW'(1);
        S_WOK: if (tgt_ok) begin
          st  <= S_LOAD;
          cnt <= '0;
        end else if (cnt == W_END) begin
          error <= 1'b1;
          st    <= S_IDLE;
        end else cnt <= cnt + CW'(1);
        S_LOAD: if (!tgt_ok) begin
          error   <= 1'b1;
          ser_clk <= 1'b0;
          ser_dat <= 1'b0;
          st      <= S_IDLE;
        end else if (tgt_loaded) begin
          st      <= S_TAIL;
          cnt     <= '0;
          tails   <= 1'b0;
          ser_dat <= 1'b0;
        end else if (in_valid) begin
          sh      <= in_data;
          ser_dat <= in_data[0];
          bitn    <= '0;
          cnt     <= '0;
          st      <= S_SHIFT;
        end else if (cnt == W_END) begin
          error <= 1'b1;
          st    <= S_IDLE;
        end else cnt <= cnt + CW'(1);
        S_SHIFT: if (!tgt_ok) begin
          error   <= 1'b1;
          ser_clk <= 1'b0;
          ser_dat <= 1'b0;
          st      <= S_IDLE;
        end else if (cnt == H_END) begin
          cnt <= '0;
          if (!ser_clk) ser_clk <= 1'b1;
          else begin
            ser_clk <= 1'b0;
            if (tgt_loaded) begin
              st      <= S_TAIL;
              tails   <= 1'b1;
              ser_dat <= 1'b0;
            end else if (bitn == 3'd7) begin
              st <= S_LOAD;
            end else begin
              bitn    <= bitn + 3'd1;
              ser_dat <= sh[1];
              sh      <= {1'b0, sh[7:1]};
            end
          end
        end else cnt <= cnt + CW'(1);
        S_TAIL: if (cnt == H_END) begin
          cnt     <= '0;
          ser_clk <= !ser_clk;
          if (ser_clk) begin
            if (tails) st <= S_WINIT;
            else tails <= 1'b1;
          end
        end else cnt <= cnt + CW'(1);
        S_WINIT: if (tgt_ready && !init_q) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end else if (cnt == W_END) begin
          error <= 1'b1;
          st    <= S_IDLE;
        end else cnt <= cnt + CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r5_dat_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dat) |-> !ser_clk);
  a_r5_dat_held_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_dat));
  a_r2_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_reset_n |-> busy);
  a_r3_no_clock_before_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WOK) |-> !ser_clk);
  a_r9_done_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tgt_ready));
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && !tgt_ok) |=> (!ser_clk && error && !busy));
  a_r12_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  a_r12_busy_ends_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || error));

endmodule

// File: tb/ps_serial_cfg_host_bench.sv
module ps_serial_cfg_host_bench;
  localparam int H = 2, PUL = 5, WT = 40;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [7:0] in_data = 0;
  logic tgt_ok = 1, tgt_loaded = 0, tgt_ready = 0;
  logic in_ready, tgt_reset_n, ser_clk, ser_dat, busy, done, error;

  always #10 clk = ~clk;

  ps_serial_cfg_host #(.DIV_HALF(H), .PULSE_CLKS(PUL), .WAIT_CLKS(WT)) u_ps_serial_cfg_host (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tgt_reset_n(tgt_reset_n), .tgt_ok(tgt_ok), .tgt_loaded(tgt_loaded),
    .tgt_ready(tgt_ready), .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy), .done(done),
    .error(error));

  int vectors = 0, miscomp = 0, cycles = 0;
  bit wd_hit = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  int ms = 0, mt = 0, mtails = 0;
  bit mdclk = 0, mdat = 0, mrst = 1, mdone = 0, merr = 0, mprev = 0;
  bit mbits[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mt = 0; mtails = 0; mdclk = 0; mdat = 0; mrst = 1;
      mdone = 0; merr = 0; mprev = 0; mbits.delete();
    end else begin
      case (ms)
        0: if (start) begin ms = 1; mt = 0; mrst = 0; mdone = 0; merr = 0; end
        1: begin mt++; if (mt == PUL) begin mrst = 1; ms = 2; mt = 0; end end
        2: if (tgt_ok) begin ms = 3; mt = 0; end
           else begin mt++; if (mt == WT) begin merr = 1; ms = 0; end end
        3: if (!tgt_ok) begin merr = 1; ms = 0; mdat = 0; mdclk = 0; end
           else if (tgt_loaded) begin ms = 5; mt = 0; mtails = 0; mdat = 0; end
           else if (in_valid) begin
             mbits.delete();
             for (int b = 0; b < 8; b++) mbits.push_back(in_data[b]);
             mdat = mbits[0]; mt = 0; ms = 4;
           end else begin mt++; if (mt == WT) begin merr = 1; ms = 0; end end
        4: if (!tgt_ok) begin merr = 1; ms = 0; mdat = 0; mdclk = 0; end
           else begin
             mt++;
             if (mt == H) mdclk = 1;
             else if (mt == 2*H) begin
               mdclk = 0; mt = 0; void'(mbits.pop_front());
               if (tgt_loaded) begin ms = 5; mtails = 1; mdat = 0; end
               else if (mbits.size() == 0) ms = 3;
               else mdat = mbits[0];
             end
           end
        5: begin
             mt++;
             if (mt == H) mdclk = 1;
             else if (mt == 2*H) begin
               mdclk = 0; mt = 0; mtails++;
               if (mtails == 2) ms = 6;
             end
           end
        6: if (tgt_ready && !mprev) begin mdone = 1; ms = 0; end
           else begin mt++; if (mt == WT) begin merr = 1; ms = 0; end end
        default: ms = 0;
      endcase
      mprev = tgt_ready;
    end
  end

  // stream source and emulated target
  logic hs = 0;
  always @(posedge clk) hs <= in_valid && in_ready;

  logic [7:0] src[$];
  int cfg_ok_delay = 2, cfg_need = 0, cfg_drop = -1, cfg_init_delay = 3;
  bit cfg_stuck = 0;
  int t_nbits = 0, t_falls = 0, t_okcnt = 0, t_initcnt = 0, t_rises = 0, t_lowcnt = 0, accepted = 0;
  bit t_prev = 0, t_seen_low = 0, t_dropped = 0;
  bit t_bits[$];

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000 && !wd_hit) begin
      wd_hit = 1;
      chk(0, "watchdog", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
    if (rst_n) begin
      chk(tgt_reset_n == mrst, "R2 tgt_reset_n", tgt_reset_n, mrst);
      chk(ser_clk == mdclk, "R4 ser_clk", ser_clk, mdclk);
      chk(ser_dat == mdat, "R5 ser_dat", ser_dat, mdat);
      chk(in_ready == ((ms == 3) && tgt_ok && !tgt_loaded), "R6 in_ready", in_ready,
          (ms == 3) && tgt_ok && !tgt_loaded);
      chk(busy == (ms != 0), "R12 busy", busy, ms != 0);
      chk(done == mdone, "R9 done", done, mdone);
      chk(error == merr, "R10 error", error, merr);
    end
    if (hs) begin void'(src.pop_front()); accepted++; end
    in_valid = src.size() > 0;
    in_data  = (src.size() > 0) ? src[0] : 8'h00;
    if (!tgt_reset_n) begin
      t_lowcnt++; tgt_ok = 0; t_seen_low = 1; t_okcnt = 0;
    end else if (t_seen_low && cfg_ok_delay >= 0 && !tgt_ok && !t_dropped) begin
      t_okcnt++;
      if (t_okcnt >= cfg_ok_delay) tgt_ok = 1;
    end
    if (ser_clk && !t_prev) begin
      t_rises++;
      if (!tgt_loaded) begin
        t_bits.push_back(ser_dat); t_nbits++;
        if (t_nbits == cfg_drop) begin tgt_ok = 0; t_dropped = 1; end
        if (t_nbits == cfg_need) tgt_loaded = 1;
      end
    end
    if (!ser_clk && t_prev && tgt_loaded) t_falls++;
    t_prev = ser_clk;
    if (cfg_stuck) tgt_ready = 1;
    else if (t_falls >= 2 && !tgt_ready) begin
      t_initcnt++;
      if (t_initcnt >= cfg_init_delay) tgt_ready = 1;
    end
  end

  task automatic run(input logic [7:0] bytes[$], input int need, input int drop,
                     input int okd, input bit stuck, input bit restart);
    @(posedge clk); #2;
    cfg_need = need; cfg_drop = drop; cfg_ok_delay = okd; cfg_stuck = stuck;
    t_nbits = 0; t_falls = 0; t_okcnt = 0; t_initcnt = 0; t_rises = 0; t_lowcnt = 0;
    accepted = 0; t_seen_low = 0; t_dropped = 0; t_bits.delete();
    tgt_ok = 1; tgt_loaded = 0; tgt_ready = stuck;
    src = bytes;
    start = 1;
    @(posedge clk); #2;
    start = 0;
    if (restart) begin
      repeat (20) @(posedge clk);
      #2 start = 1;
      @(posedge clk); #2 start = 0;
    end
    for (int i = 0; i < 20000 && busy; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
  endtask

  logic [7:0] seq[$];
  int expb;

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk); #1;
    chk(tgt_reset_n && !ser_clk && !ser_dat && !busy && !done && !error && !in_ready,
        "R1 reset state", {tgt_reset_n, ser_clk, ser_dat, busy, done, error, in_ready}, 7'b1000000);

    // normal load with a start pulse during busy
    seq = '{8'h02, 8'h1B, 8'hEE, 8'h01, 8'hFA};
    run(seq, 40, -1, 3, 0, 1);
    chk(done && !error, "R9 user mode reached", done, 1);
    chk(t_lowcnt == PUL, "R2 pulse width, restart ignored", t_lowcnt, PUL);
    chk(t_nbits == 40, "R4 bit count", t_nbits, 40);
    for (int i = 0; i < t_bits.size() && i < 40; i++) begin
      expb = (seq[i/8] >> (i % 8)) & 1;
      chk(t_bits[i] == expb, $sformatf("R4 bit %0d lsb-first", i), t_bits[i], expb);
    end
    chk(t_falls == 2, "R8 trailing falls", t_falls, 2);
    chk(accepted == 5, "R6 bytes taken", accepted, 5);

    // loaded flag mid-byte with bytes still queued
    seq = '{8'hA5, 8'h3C, 8'h77, 8'h81, 8'h42, 8'h99};
    run(seq, 12, -1, 1, 0, 0);
    chk(accepted == 2, "R7 no byte after loaded", accepted, 2);
    chk(t_nbits == 12, "R7 bits stop", t_nbits, 12);
    chk(t_rises == 13, "R8 one extra pulse", t_rises, 13);
    chk(t_falls == 2, "R8 trailing falls", t_falls, 2);
    chk(done, "R9 done after early load", done, 1);

    // status never rises
    seq = '{8'h55};
    run(seq, 8, -1, -1, 0, 0);
    chk(error && !done, "R3 status timeout", error, 1);
    chk(t_rises == 0, "R3 no clock before status", t_rises, 0);
    chk(accepted == 0, "R3 no byte before status", accepted, 0);

    // stream runs dry
    seq = '{8'hC3};
    run(seq, 24, -1, 2, 0, 0);
    chk(error && !done, "R10 stream dry", error, 1);
    chk(t_nbits == 8, "R10 bits sent", t_nbits, 8);

    // status drops mid-byte
    seq = '{8'hF0, 8'h0F, 8'h33};
    run(seq, 24, 5, 2, 0, 0);
    chk(error && !done, "R11 abort error", error, 1);
    chk(!ser_clk && !ser_dat, "R11 lines low", {ser_clk, ser_dat}, 0);
    chk(t_nbits == 5, "R11 bits before abort", t_nbits, 5);

    // ready already high, no edge
    seq = '{8'h12, 8'h34};
    run(seq, 16, -1, 2, 1, 0);
    chk(error && !done, "R9 no ready edge", error, 1);
    chk(t_falls == 2, "R8 tail before ready wait", t_falls, 2);

    // clean run after failures: status cleared by start
    seq = '{8'h6E};
    run(seq, 8, -1, 2, 0, 0);
    chk(done && !error, "R12 status cleared on start", {done, error}, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule